// File: doc/BRIEF.md
# Strobed Parallel Port Handshake

This peripheral gives a small processor two strobed handshake paths that run side by side. On the output side, every bus write to the output data register puts the new byte on the output pins and pulses an output strobe for exactly two bus clock cycles. The strobe polarity comes from a control bit. On the input side, an external device pulses an input strobe. After synchronization, the selected edge of that strobe copies the input pins into a capture latch that is separate from the live pin view.

The control register sets the output strobe polarity, the active input strobe edge and an interrupt enable. It also reports a capture flag. Software clears the flag by reading the control register while the flag is set and then reading the capture latch. The interrupt request is the flag gated by the enable. The live input pins stay readable at all times through their own register, whether or not strobed capture is in use.

Top module: `strobe_pio`

## Requirements
- R1: After reset, the control register reads 0x00, the capture latch reads 0x00, the output pins read 0x00, the interrupt request is low, and the output strobe rests high (active-low idle).
- R2: A write to address 1 puts the written byte on the output pins from the next cycle onward. Reading address 1 returns that byte.
- R3: Each write to address 1 makes the output strobe active for exactly the two cycles that follow the write edge. The strobe then returns to its idle level.
- R4: Control bit 0 selects the output strobe polarity: 0 means active-low (idle high) and 1 means active-high (idle low). A change takes effect on the next cycle.
- R5: A write to address 1 while a strobe pulse is active restarts the two-cycle pulse from that write.
- R6: The input strobe passes through a two-flop synchronizer. Control bit 1 selects the capturing edge: 0 selects falling and 1 selects rising. The selected edge copies the input pins into the latch at address 3 three cycles after the strobe changes. The other edge and any later pin changes leave the latch unchanged, and each edge captures at most once.
- R7: Address 2 always returns the current input pin levels, including while strobed capture is in use.
- R8: Control bit 7 is the capture flag. Every capture sets it, and writes to bit 7 have no effect on it.
- R9: The flag clears only when address 0 is read while the flag is set and address 3 is read after that. A latch read without that prior control read leaves the flag set.
- R10: Control bit 6 is the interrupt enable. The interrupt request equals the capture flag ANDed with bit 6.
- R11: An output write and an input capture in the same window both complete correctly and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe for the selected register |
| rd_i | input | 1 | Read strobe for the selected register |
| addr_i | input | 2 | Register address: 0 control, 1 output data, 2 live pins, 3 capture latch |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; zero when no read is active |
| out_port_o | output | 8 | Output port pins |
| out_stb_o | output | 1 | Output strobe pin |
| in_port_i | input | 8 | Input port pins |
| in_stb_i | input | 1 | Input strobe pin, asynchronous |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The bench issues back-to-back data writes, which a design that ignores restarts would show as a pulse one cycle short. It checks the interrupt one cycle before and at the third cycle after a strobe edge, which catches a design that samples the strobe with the wrong synchronizer depth. It reads the latch without first reading the control register, and writes a one to the flag bit, which catches flag logic that clears on any latch read or that accepts a write to the flag. An output write and a capture run in the same cycles, with the unselected edge driven in between, which catches a design that captures on both edges or that ties the two paths together.

// File: rtl/strobe_pio_pkg.sv
package strobe_pio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_OUT   = 2'd1,
    REG_PIN   = 2'd2,
    REG_LATCH = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_POL_BIT  = 0;
  localparam int unsigned CTRL_EDGE_BIT = 1;
  localparam int unsigned CTRL_IE_BIT   = 6;
  localparam int unsigned CTRL_FLAG_BIT = 7;

  typedef struct packed {
    logic out_pol_high;
    logic rise_edge;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/strobe_pio_out_strobe.sv
module strobe_pio_out_strobe #(
  parameter int unsigned STB_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(STB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STB_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_load_starts_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o);
  p_pulse_not_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |=> active_o);
  p_restart_extends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && load_i) |=> (cnt_q == CNT_LOAD));
endmodule

// File: rtl/strobe_pio_in_capture.sv
module strobe_pio_in_capture #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              rise_sel_i,
  input  logic [DATA_W-1:0] pins_i,
  output logic              capture_o,
  output logic [DATA_W-1:0] latch_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;
  logic                   rise_det, fall_det;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= stb_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], stb_i};
      end
    end
  endgenerate

  assign synced   = sync_q[SYNC_STAGES-1];
  assign rise_det = synced & ~prev_q;
  assign fall_det = ~synced & prev_q;
  assign capture_o = rise_sel_i ? rise_det : fall_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_o <= '0;
    end else begin
      prev_q <= synced;
      if (capture_o) latch_o <= pins_i;
    end
  end

  p_single_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);
  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_o |=> $stable(latch_o));
endmodule

// File: rtl/strobe_pio_regs.sv
module strobe_pio_regs
  import strobe_pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pin_i,
  input  logic [DATA_W-1:0] latch_i,
  input  logic              capture_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_load_o,
  output logic              flag_o
);
  reg_sel_e sel_reg;
  logic     wr_ctrl, wr_out, rd_ctrl, rd_latch;
  logic     flag_q, armed_q;
  logic     unused_wdata;

  assign sel_reg  = reg_sel_e'(addr_i);
  assign wr_ctrl  = sel_i & wr_i & (sel_reg == REG_CTRL);
  assign wr_out   = sel_i & wr_i & (sel_reg == REG_OUT);
  assign rd_ctrl  = sel_i & rd_i & (sel_reg == REG_CTRL);
  assign rd_latch = sel_i & rd_i & (sel_reg == REG_LATCH);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      out_data_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.out_pol_high <= wdata_i[CTRL_POL_BIT];
        ctrl_o.rise_edge    <= wdata_i[CTRL_EDGE_BIT];
        ctrl_o.irq_en       <= wdata_i[CTRL_IE_BIT];
      end
      if (wr_out) out_data_o <= wdata_i;
    end
  end

  // flag clear needs a control read with flag set, then a latch read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (capture_i)                flag_q <= 1'b1;
      else if (rd_latch && armed_q) flag_q <= 1'b0;
      if (rd_latch)                 armed_q <= 1'b0;
      else if (rd_ctrl && flag_q)   armed_q <= 1'b1;
    end
  end

  assign flag_o     = flag_q;
  assign out_load_o = wr_out;

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      unique case (sel_reg)
        REG_CTRL: begin
          rdata_o[CTRL_POL_BIT]  = ctrl_o.out_pol_high;
          rdata_o[CTRL_EDGE_BIT] = ctrl_o.rise_edge;
          rdata_o[CTRL_IE_BIT]   = ctrl_o.irq_en;
          rdata_o[CTRL_FLAG_BIT] = flag_q;
        end
        REG_OUT:   rdata_o = out_data_o;
        REG_PIN:   rdata_o = pin_i;
        REG_LATCH: rdata_o = latch_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> flag_q);
  p_flag_rise_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(capture_i));
  p_flag_clear_seq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(rd_latch && armed_q));
endmodule

// File: rtl/strobe_pio.sv
module strobe_pio
  import strobe_pio_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STB_CYCLES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] out_port_o,
  output logic              out_stb_o,
  input  logic [DATA_W-1:0] in_port_i,
  input  logic              in_stb_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              out_load, stb_active, capture, flag;
  logic [DATA_W-1:0] latch;

  strobe_pio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .pin_i      (in_port_i),
    .latch_i    (latch),
    .capture_i  (capture),
    .ctrl_o     (ctrl),
    .out_data_o (out_port_o),
    .out_load_o (out_load),
    .flag_o     (flag)
  );

  strobe_pio_out_strobe #(.STB_CYCLES(STB_CYCLES)) u_out_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (out_load),
    .active_o (stb_active)
  );

  strobe_pio_in_capture #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_in_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (in_stb_i),
    .rise_sel_i (ctrl.rise_edge),
    .pins_i     (in_port_i),
    .capture_o  (capture),
    .latch_o    (latch)
  );

  assign out_stb_o = ctrl.out_pol_high ? stb_active : ~stb_active;
  assign irq_o     = flag & ctrl.irq_en;

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (irq_o == ctrl.irq_en));
  p_out_port_follows_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_load |=> (out_port_o == $past(wdata_i)));
endmodule

// File: tb/strobe_pio_bench.sv
module strobe_pio_bench;
  localparam logic [1:0] A_CTRL = 2'd0, A_OUT = 2'd1, A_PIN = 2'd2, A_LATCH = 2'd3;
  localparam int K_STB = 0, K_PORT = 1, K_IRQ = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, in_port = '0;
  logic       in_stb = 1'b0;
  logic [7:0] rdata, out_port;
  logic       out_stb, irq;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  strobe_pio u_strobe_pio (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .out_port_o(out_port),
    .out_stb_o(out_stb), .in_port_i(in_port), .in_stb_i(in_stb), .irq_o(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(logic [7:0] act, logic [7:0] exp, string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  task automatic expect_at(int dly, int kind, logic [7:0] v, string req);
    exp_t e;
    e.due = cyc + dly; e.kind = kind; e.exp = v; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: pops due items and compares against outputs
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        logic [7:0] act;
        case (sb_q[i].kind)
          K_STB:   act = {7'b0, out_stb};
          K_PORT:  act = out_port;
          default: act = {7'b0, irq};
        endcase
        chk(act, sb_q[i].exp, sb_q[i].req);
        sb_q.delete(i);
      end
    end
  end

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    sel = 1'b1; rd = 1'b1; addr = a;
    #1 chk(rdata, exp, req);
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({7'b0, out_stb}, 8'h01, "R1");
    chk({7'b0, irq}, 8'h00, "R1");
    chk(out_port, 8'h00, "R1");
    rd_chk(A_CTRL, 8'h00, "R1");
    rd_chk(A_LATCH, 8'h00, "R1");

    // R2/R3 active-low pulse
    expect_at(1, K_PORT, 8'hA5, "R2");
    expect_at(1, K_STB, 8'h00, "R3");
    expect_at(2, K_STB, 8'h00, "R3");
    expect_at(3, K_STB, 8'h01, "R3");
    bus_wr(A_OUT, 8'hA5);
    repeat (3) @(negedge clk);
    rd_chk(A_OUT, 8'hA5, "R2");

    // R4 polarity high
    bus_wr(A_CTRL, 8'h01);
    chk({7'b0, out_stb}, 8'h00, "R4");
    expect_at(1, K_STB, 8'h01, "R4");
    expect_at(2, K_STB, 8'h01, "R4");
    expect_at(3, K_STB, 8'h00, "R4");
    bus_wr(A_OUT, 8'h3C);
    repeat (3) @(negedge clk);

    // R5 restart on back-to-back writes
    expect_at(1, K_STB, 8'h01, "R5");
    expect_at(2, K_STB, 8'h01, "R5");
    expect_at(2, K_PORT, 8'h22, "R5");
    expect_at(3, K_STB, 8'h01, "R5");
    expect_at(4, K_STB, 8'h00, "R5");
    bus_wr(A_OUT, 8'h11);
    bus_wr(A_OUT, 8'h22);
    repeat (3) @(negedge clk);

    // R6 falling-edge select; rising edge ignored
    bus_wr(A_CTRL, 8'h41);
    in_port = 8'h77;
    in_stb = 1'b1;
    repeat (5) @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R6");
    rd_chk(A_LATCH, 8'h00, "R6");
    in_port = 8'h5A;
    in_stb = 1'b0;
    expect_at(2, K_IRQ, 8'h00, "R6");
    expect_at(3, K_IRQ, 8'h01, "R10");
    repeat (4) @(negedge clk);
    in_port = 8'hFF;
    rd_chk(A_PIN, 8'hFF, "R7");
    rd_chk(A_LATCH, 8'h5A, "R6");
    chk({7'b0, irq}, 8'h01, "R9");
    rd_chk(A_CTRL, 8'hC1, "R8");
    rd_chk(A_LATCH, 8'h5A, "R9");
    chk({7'b0, irq}, 8'h00, "R9");
    rd_chk(A_CTRL, 8'h41, "R9");

    // R8 flag write ignored; rising edge select
    bus_wr(A_CTRL, 8'hC3);
    rd_chk(A_CTRL, 8'h43, "R8");
    chk({7'b0, irq}, 8'h00, "R8");
    in_port = 8'h96;
    in_stb = 1'b1;
    expect_at(2, K_IRQ, 8'h00, "R6");
    expect_at(3, K_IRQ, 8'h01, "R6");
    repeat (4) @(negedge clk);
    in_port = 8'h00;
    in_stb = 1'b0;
    repeat (5) @(negedge clk);
    rd_chk(A_PIN, 8'h00, "R7");
    rd_chk(A_LATCH, 8'h96, "R6");
    chk({7'b0, irq}, 8'h01, "R9");

    // R10 enable gating
    bus_wr(A_CTRL, 8'h03);
    chk({7'b0, irq}, 8'h00, "R10");
    rd_chk(A_CTRL, 8'h83, "R10");
    bus_wr(A_CTRL, 8'h43);
    chk({7'b0, irq}, 8'h01, "R10");
    rd_chk(A_CTRL, 8'hC3, "R9");
    rd_chk(A_LATCH, 8'h96, "R9");
    chk({7'b0, irq}, 8'h00, "R9");

    // R11 concurrent output write and capture
    in_port = 8'hE7;
    in_stb = 1'b1;
    expect_at(1, K_PORT, 8'h6B, "R11");
    expect_at(1, K_STB, 8'h01, "R11");
    expect_at(2, K_STB, 8'h01, "R11");
    expect_at(3, K_STB, 8'h00, "R11");
    expect_at(3, K_IRQ, 8'h01, "R11");
    bus_wr(A_OUT, 8'h6B);
    repeat (4) @(negedge clk);
    rd_chk(A_CTRL, 8'hC3, "R11");
    rd_chk(A_LATCH, 8'hE7, "R11");
    rd_chk(A_OUT, 8'h6B, "R11");
    chk({7'b0, irq}, 8'h00, "R11");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule